// File: doc/BRIEF.md
# Scanline-Prescaled Interrupt Timer

This block is an 8-bit interrupt timer of the kind found in a game-cartridge memory mapper. Software loads a reload value into a latch register. A write to the control register then starts the counter from that value. The counter counts upward, and when it steps past 0xFF it loads the latch value again and can raise an active-high interrupt request.

Counting is paced by a prescaler that runs from the CPU clock enable, so that in the default mode the counter advances about once per video scanline. In cycle mode the counter advances on every enabled CPU cycle instead.

The prescaler is built from two chained counters:

- a 7-bit fine counter, which advances on every CPU clock enable;
- a 2-bit phase counter, which advances each time the fine counter wraps.

The wrap rule gives scanline periods of 114, 114 and 113 cycles in turn.

Three control bits are kept independent of one another:

- repeat: whether the counter keeps counting after an overflow;
- interrupt enable: whether an overflow raises the request;
- cycle mode: whether the prescaler is bypassed.

An acknowledge write only clears the request. It does not start a halted counter again.

Top module: `irq_scan_timer`

## Requirements
- R1: After reset the interrupt output is low, the counter is halted and the latch is zero. No interrupt occurs, whatever the clock enable does, until a control write is made.
- R2: In scanline mode (control bit 2 = 0), the fine counter returns to zero in the enabled cycle in which `(fine[0] | phase[1]) & fine[6] & fine[5] & fine[4]` holds. That wrap issues one counter tick and advances the phase counter through 0, 1, 2, 0. Starting from a control write, the ticks come after 114, 114, 113 and then 114 enabled cycles.
- R3: In cycle mode (control bit 2 = 1), the counter advances once per enabled cycle. The prescaler output is ignored.
- R4: When a counter step is taken at 0xFF, the counter loads the latch value. If interrupt enable (control bit 1) is set, the interrupt output is high from the next cycle.
- R5: With repeat (control bit 0) set, the counter keeps counting from the reloaded value after an overflow.
- R6: With repeat clear, the counter halts at the reloaded value after an overflow. An acknowledge write does not restart it.
- R7: With interrupt enable clear, the prescaler and the counter run normally, but the interrupt output never rises.
- R8: Any control write, whatever its data, reloads the counter from the latch, clears both prescaler counters, starts the counter and clears the interrupt output. This takes effect in the same cycle, and the control write takes priority over any tick or overflow in that cycle.
- R9: An acknowledge write clears the interrupt output. An acknowledge made before an overflow does not prevent the interrupt. An overflow in the same cycle as an acknowledge leaves the output high.
- R10: Once high, the interrupt output stays high until an acknowledge write or a control write.
- R11: A latch write does not change the count in progress. It takes effect at the next reload.
- R12: While the clock enable is low, neither the prescaler nor the counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | CPU cycle enable; paces the prescaler and the cycle mode |
| wr_latch | input | 1 | Write `wdata` to the reload latch |
| wr_ctrl | input | 1 | Write control bits and restart the counter |
| wr_ack | input | 1 | Acknowledge (clear) the interrupt request |
| wdata | input | 8 | Write data |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two collisions need checking. An acknowledge write can land in the same cycle as an overflow step, and a control write can land in the same cycle as a prescaler tick.

The first collision is provoked on purpose in cycle mode with the latch at 0xFF, where every enabled cycle overflows. The acknowledge is issued with the clock enable high, and the output is expected to stay high. The second collision arises in the constrained-random phase, where control and acknowledge writes hit arbitrary prescaler phases.

In both cases the interrupt output is compared each cycle with a reference model in the bench. That model encodes the priorities: a control write beats everything, and a new overflow beats an acknowledge.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

    // Prescaler geometry; the wrap rule below depends on these sizes.
    localparam int FINE_W  = 7;
    localparam int PHASE_W = 2;
    localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(2);

    // Control register bit positions.
    localparam int CB_REPEAT = 0;
    localparam int CB_IRQEN  = 1;
    localparam int CB_CYCLE  = 2;

    typedef struct packed {
        logic cycle_mode;
        logic irq_en;
        logic repeat_on;
    } tmr_ctrl_t;

    typedef struct packed {
        logic [FINE_W-1:0]  fine;
        logic [PHASE_W-1:0] phase;
    } pre_state_t;

    function automatic tmr_ctrl_t decode_ctrl(input logic [7:0] d);
        tmr_ctrl_t c;
        c.cycle_mode = d[CB_CYCLE];
        c.irq_en     = d[CB_IRQEN];
        c.repeat_on  = d[CB_REPEAT];
        return c;
    endfunction

    // Fine counter wraps at 113, or at 112 once the phase has reached 2.
    function automatic logic fine_wrap(input pre_state_t s);
        return (s.fine[0] | s.phase[1]) & s.fine[6] & s.fine[5] & s.fine[4];
    endfunction

endpackage

// File: rtl/irq_prescaler.sv
module irq_prescaler
    import irq_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic clear,
    output logic tick,
    output pre_state_t state
);
    pre_state_t st_q;
    logic       wrap;

    assign wrap  = fine_wrap(st_q);
    assign tick  = ce & wrap;
    assign state = st_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st_q <= '0;
        end else if (ce) begin
            if (wrap) begin
                st_q.fine  <= '0;
                st_q.phase <= (st_q.phase == PHASE_LAST) ? '0 : st_q.phase + 1'b1;
            end else begin
                st_q.fine <= st_q.fine + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_main_counter.sv
module irq_main_counter
    import irq_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             tick,
    input  logic             restart,
    input  logic             ack,
    input  tmr_ctrl_t        ctrl,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             fire,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             irq_q;
    logic             step;
    logic             at_top;

    assign step    = run_q & (ctrl.cycle_mode ? ce : tick);
    assign at_top  = (cnt_q == CNT_TOP);
    assign fire    = step & at_top & ctrl.irq_en;
    assign count   = cnt_q;
    assign running = run_q;
    assign irq     = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            irq_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= reload;
            run_q <= 1'b1;
            irq_q <= 1'b0;
        end else begin
            if (ack) begin
                irq_q <= 1'b0;
            end
            if (step) begin
                if (at_top) begin
                    cnt_q <= reload;
                    if (ctrl.irq_en) begin
                        irq_q <= 1'b1;
                    end
                    if (!ctrl.repeat_on) begin
                        run_q <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_scan_timer.sv
module irq_scan_timer
    import irq_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_ce,
    input  logic       wr_latch,
    input  logic       wr_ctrl,
    input  logic       wr_ack,
    input  logic [7:0] wdata,
    output logic       irq
);
    logic [CNT_W-1:0] latch_q;
    tmr_ctrl_t        ctrl_q;
    logic             pre_tick;
    pre_state_t       pre_st;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_run;
    logic             cnt_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (wr_latch) begin
                latch_q <= CNT_W'(wdata);
            end
            if (wr_ctrl) begin
                ctrl_q <= decode_ctrl(wdata);
            end
        end
    end

    irq_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .ce    (cpu_ce),
        .clear (wr_ctrl),
        .tick  (pre_tick),
        .state (pre_st)
    );

    irq_main_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ce      (cpu_ce),
        .tick    (pre_tick),
        .restart (wr_ctrl),
        .ack     (wr_ack),
        .ctrl    (ctrl_q),
        .reload  (latch_q),
        .count   (cnt_val),
        .running (cnt_run),
        .fire    (cnt_fire),
        .irq     (irq)
    );
endmodule

// File: rtl/irq_scan_timer_chk.sv
module irq_scan_timer_chk
    import irq_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_ce,
    input logic             wr_ctrl,
    input logic             wr_ack,
    input logic             irq,
    input tmr_ctrl_t        ctrl_q,
    input logic [CNT_W-1:0] latch_q,
    input pre_state_t       pre_st,
    input logic [CNT_W-1:0] cnt_val,
    input logic             cnt_run,
    input logic             cnt_fire
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!irq && !cnt_run));

    // R2
    a_r2_fine_bound: assert property (@(posedge clk) disable iff (rst)
        (pre_st.fine <= 7'd113) && (pre_st.phase <= 2'd2));

    // R12
    a_r12_hold_without_ce: assert property (@(posedge clk) disable iff (rst)
        (!cpu_ce && !wr_ctrl) |=> ($stable(pre_st) && $stable(cnt_val)));

    // R6
    a_r6_stays_halted: assert property (@(posedge clk) disable iff (rst)
        (!cnt_run && !wr_ctrl) |=> !cnt_run);

    // R7
    a_r7_no_rise_disabled: assert property (@(posedge clk) disable iff (rst)
        (!irq && !ctrl_q.irq_en && !wr_ctrl) |=> !irq);

    // R8
    a_r8_ctrl_restart: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (pre_st == '0 && cnt_val == $past(latch_q) && cnt_run && !irq));

    // R9
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && !wr_ctrl && !cnt_fire) |=> !irq);
    a_r9_fire_wins: assert property (@(posedge clk) disable iff (rst)
        (cnt_fire && !wr_ctrl) |=> irq);

    // R10
    a_r10_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_ack && !wr_ctrl) |=> irq);
endmodule

bind irq_scan_timer irq_scan_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_ce   (cpu_ce),
    .wr_ctrl  (wr_ctrl),
    .wr_ack   (wr_ack),
    .irq      (irq),
    .ctrl_q   (ctrl_q),
    .latch_q  (latch_q),
    .pre_st   (pre_st),
    .cnt_val  (cnt_val),
    .cnt_run  (cnt_run),
    .cnt_fire (cnt_fire)
);

// File: tb/irq_scan_timer_bench.sv
module irq_scan_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_ce = 1'b0;
    logic       wr_latch = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic       wr_ack = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // Reference model state
    int m_fine, m_phase, m_cnt, m_latch;
    bit m_rep, m_en, m_cyc, m_run, m_irq;

    irq_scan_timer u_irq_scan_timer (
        .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .wr_latch(wr_latch),
        .wr_ctrl(wr_ctrl), .wr_ack(wr_ack), .wdata(wdata), .irq(irq)
    );

    always #5 clk = ~clk;

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not complete (got hang, expected finish)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic model_reset();
        m_fine = 0; m_phase = 0; m_cnt = 0; m_latch = 0;
        m_rep = 0; m_en = 0; m_cyc = 0; m_run = 0; m_irq = 0;
    endtask

    function automatic bit model_tick(int f, int p);
        return (f == 113) || (f == 112 && p == 2);
    endfunction

    task automatic model_step(bit ce, bit wl, bit wc, bit wa, int d);
        bit tk;
        bit stp;
        int old_latch;
        tk = ce && model_tick(m_fine, m_phase);
        old_latch = m_latch;
        if (wc) begin
            m_rep = d[0]; m_en = d[1]; m_cyc = d[2];
            m_cnt = old_latch; m_fine = 0; m_phase = 0; m_run = 1; m_irq = 0;
        end else begin
            if (ce) begin
                if (tk) begin
                    m_fine = 0;
                    m_phase = (m_phase + 1) % 3;
                end else begin
                    m_fine++;
                end
            end
            if (wa) m_irq = 0;
            stp = m_run && (m_cyc ? ce : tk);
            if (stp) begin
                if (m_cnt == 255) begin
                    m_cnt = old_latch;
                    if (m_en) m_irq = 1;
                    if (!m_rep) m_run = 0;
                end else begin
                    m_cnt++;
                end
            end
        end
        if (wl) m_latch = d & 255;
    endtask

    task automatic check(bit act, bit exp, string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: irq actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle; inputs driven at negedge, result sampled after the edge.
    task automatic cyc(bit ce, bit wl = 0, bit wc = 0, bit wa = 0, int d = 0);
        cpu_ce = ce; wr_latch = wl; wr_ctrl = wc; wr_ack = wa; wdata = d[7:0];
        @(posedge clk);
        model_step(ce, wl, wc, wa, d);
        #2;
        check(irq, m_irq, cur_req);
        @(negedge clk);
        cpu_ce = 0; wr_latch = 0; wr_ctrl = 0; wr_ack = 0;
    endtask

    task automatic setup(int lat, int ctl);
        cyc(0, 1, 0, 0, lat);
        cyc(0, 0, 1, 0, ctl);
    endtask

    initial begin
        int n;
        int periods[3];
        int exp_p[3];
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        check(irq, 1'b0, "R1 reset");
        @(negedge clk);

        // R1: no interrupt before any control write
        cur_req = "R1";
        for (int i = 0; i < 300; i++) cyc(1);

        // R2: scanline tick spacing 114,114,113 with latch FF
        cur_req = "R2";
        exp_p[0] = 114; exp_p[1] = 114; exp_p[2] = 113;
        setup(8'hFF, 3'b011);
        for (int k = 0; k < 3; k++) begin
            n = 0;
            do begin
                cyc(1);
                n++;
            end while (!irq && n < 200);
            periods[k] = n;
            n_vec++;
            if (n != exp_p[k]) begin
                n_bad++;
                $display("FAIL R2: period %0d actual=%0d expected=%0d", k, n, exp_p[k]);
            end
            cyc(0, 0, 0, 1);
        end

        // R3 / R4: cycle mode, FD -> FE -> FF -> overflow on 3rd enable
        cur_req = "R3";
        setup(8'hFD, 3'b111);
        cyc(1); cyc(1);
        check(irq, 1'b0, "R3 before third enable");
        cyc(1);
        check(irq, 1'b1, "R4 overflow raises irq");

        // R10: held while idle
        cur_req = "R10";
        for (int i = 0; i < 20; i++) cyc(0);
        check(irq, 1'b1, "R10 irq held");

        // R5: repeat continues from reload (FD again: 3 more enables)
        cur_req = "R5";
        cyc(0, 0, 0, 1);
        cyc(1); cyc(1);
        check(irq, 1'b0, "R5 mid count");
        cyc(1);
        check(irq, 1'b1, "R5 second overflow");

        // R9: overflow coincident with acknowledge keeps irq high
        cur_req = "R9";
        setup(8'hFF, 3'b111);
        cyc(1);
        cyc(1, 0, 0, 1);
        check(irq, 1'b1, "R9 overflow beats ack");
        cyc(0, 0, 0, 1);
        check(irq, 1'b0, "R9 ack clears");
        // ack before overflow does not stop it
        setup(8'hFE, 3'b110);
        cyc(0, 0, 0, 1);
        cyc(1); cyc(1);
        check(irq, 1'b1, "R9 early ack ignored");

        // R6: one-shot halts; ack does not restart
        cur_req = "R6";
        cyc(0, 0, 0, 1);
        for (int i = 0; i < 400; i++) cyc(1);
        check(irq, 1'b0, "R6 halted after one-shot");

        // R7: enable clear, counter runs but irq never rises
        cur_req = "R7";
        setup(8'hFF, 3'b101);
        for (int i = 0; i < 600; i++) cyc(1);
        check(irq, 1'b0, "R7 no irq with enable clear");

        // R8: control write mid-count reloads
        cur_req = "R8";
        setup(8'hFD, 3'b111);
        cyc(1); cyc(1);
        cyc(0, 0, 1, 0, 3'b111);
        cyc(1); cyc(1);
        check(irq, 1'b0, "R8 reload delayed overflow");
        cyc(1);
        check(irq, 1'b1, "R8 overflow after reload");
        cyc(0, 0, 1, 0, 8'h00);
        check(irq, 1'b0, "R8 control write clears irq");

        // R11: latch write mid-count does not change the count
        cur_req = "R11";
        setup(8'hFE, 3'b111);
        cyc(0, 1, 0, 0, 8'h00);
        cyc(1);
        check(irq, 1'b0, "R11 one step");
        cyc(1);
        check(irq, 1'b1, "R11 old count kept");

        // R12: no enable, no progress
        cur_req = "R12";
        setup(8'hFF, 3'b111);
        for (int i = 0; i < 50; i++) cyc(0);
        check(irq, 1'b0, "R12 no progress without enable");

        // Random mix with fixed seed
        cur_req = "R8/R9 random";
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 20000; i++) begin
            int r;
            bit ce, wl, wc, wa;
            r  = $urandom_range(0, 999);
            ce = ($urandom_range(0, 9) != 0);
            wc = (r < 4);
            wa = (r >= 4 && r < 40);
            wl = (r >= 40 && r < 60);
            cyc(ce, wl, wc, wa, $urandom_range(0, 255));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule